// File: doc/BRIEF.md
# Clock-Stop Suspend Sequencer

This block runs entirely from an always-on 32 kHz clock and steps the system into and out of a deep suspend in which the main clocks are gated off. When power management asks for suspend, it raises the suspend request to the processor. Once the processor acknowledges, and only if clock stopping has been enabled, it raises a clock-stop indicator. That indicator feeds the enables of the clock generators, so the processor and system clocks halt while it is high.

While the main clocks are stopped, the sequencer keeps watching for wake events on the slow clock. A wake event is either an SMI or an unmasked interrupt. When one arrives, the clock-stop indicator falls at once so that the clocks restart. The suspend request is still held, and an SMI output is driven for a programmable PLL re-sync window of 0 to 15 milliseconds. The sequencer then releases both lines together, and the processor comes up into management mode with stable clocks.

If a wake event arrives while the handshake is still under way, entry is abandoned and the clocks are never stopped. All asynchronous inputs pass through a two-flop synchroniser before the control logic sees them.

Top module: `clk_stop_seq`

## Requirements
- R1: After reset, clkStop, suspReq and smiHold are all 0.
- R2: A high suspendGo seen in the idle state raises suspReq on the third rising slow-clock edge after it is applied, with clkStop still 0.
- R3: clkStop rises only when suspReq is held and the synchronised procAck and stopEn are both 1. With stopEn at 0, a completed handshake leaves clkStop at 0 and suspReq at 1.
- R4: While clkStop is 1, a wake (smiWake or irqWake high) clears clkStop and raises smiHold on the third rising edge after it is applied, with suspReq still 1.
- R5: After clkStop falls on a wake, suspReq and smiHold stay 1 for exactly resyncMs*33+1 slow-clock cycles and then fall together in the same cycle. One millisecond is 33 slow-clock cycles.
- R6: A resyncMs setting of 0 releases suspReq and smiHold one cycle after clkStop falls.
- R7: A wake that arrives during the handshake, before clkStop has risen, drops suspReq on the third rising edge after it is applied. clkStop and smiHold never rise during that attempt.
- R8: smiHold and clkStop are never 1 together, and smiHold is 1 only while suspReq is 1.
- R9: In the idle state, wake inputs have no effect: all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkSlow | input | 1 | Always-running 32 kHz clock |
| rstN | input | 1 | Asynchronous active-low reset |
| suspendGo | input | 1 | Suspend entry request from power management |
| procAck | input | 1 | Processor suspend acknowledge |
| stopEn | input | 1 | Configuration enable for stopping clocks |
| smiWake | input | 1 | SMI wake event |
| irqWake | input | 1 | Unmasked interrupt wake event |
| resyncMs | input | 4 | PLL re-sync delay in milliseconds (0 to 15) |
| clkStop | output | 1 | Clock-generator enable gate; 1 stops the clocks |
| suspReq | output | 1 | Suspend request held to the processor |
| smiHold | output | 1 | SMI driven during the re-sync window |

## Verification
The bench builds the block with its default parameters: 4 delay bits, 33 slow cycles per millisecond and two synchroniser stages. This makes the whole 0 to 15 ms range reachable, up to 496 re-sync cycles, within a short run, so the shortest, longest and intermediate windows are all timed edge by edge. The fixed three-edge latency through the synchroniser and the state register is what every sampling point relies on. The handshake abort and the disabled clock-stop cases are therefore checked at exact cycles.

// File: rtl/clk_stop_seq_pkg.sv
package clk_stop_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_HANDSHAKE = 3'd1,
    ST_STOPPED   = 3'd2,
    ST_RESYNC    = 3'd3,
    ST_RELEASE   = 3'd4
  } seqState_t;

  // strobes from control to the delay counter
  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clkSlow,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clkSlow or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/clk_stop_datapath.sv
module clk_stop_datapath
  import clk_stop_seq_pkg::*;
#(
  parameter int DELAY_W    = 4,
  parameter int CYC_PER_MS = 33
) (
  input  logic               clkSlow,
  input  logic               rstN,
  input  cntStrobe_t         strobe,
  input  logic [DELAY_W-1:0] delayMs,
  output logic               cntZero
);

  localparam int MAX_MS = (1 << DELAY_W) - 1;
  localparam int CNT_W  = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clkSlow or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= CNT_W'(int'(delayMs) * CYC_PER_MS);
    end else if (strobe.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // R5: the window counter never wraps below zero
  a_r5_no_underflow: assert property (@(posedge clkSlow) disable iff (!rstN)
    (strobe.dec && !strobe.load) |-> (cnt != '0));

  // R5: a load and a decrement are never requested together
  a_r5_strobe_exclusive: assert property (@(posedge clkSlow) disable iff (!rstN)
    !(strobe.load && strobe.dec));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_seq_pkg::*;
(
  input  logic       clkSlow,
  input  logic       rstN,
  input  logic       goS,
  input  logic       ackS,
  input  logic       enS,
  input  logic       wakeS,
  input  logic       cntZero,
  output cntStrobe_t strobe,
  output logic       clkStop,
  output logic       suspReq,
  output logic       smiHold
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:      if (goS) stateNext = ST_HANDSHAKE;
      ST_HANDSHAKE: begin
        if (wakeS)            stateNext = ST_RELEASE;
        else if (ackS && enS) stateNext = ST_STOPPED;
      end
      ST_STOPPED:   if (wakeS) stateNext = ST_RESYNC;
      ST_RESYNC:    if (cntZero) stateNext = ST_RELEASE;
      ST_RELEASE:   stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clkSlow or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load = (state == ST_STOPPED) && wakeS;
    strobe.dec  = (state == ST_RESYNC) && !cntZero;
  end

  assign clkStop = (state == ST_STOPPED);
  assign suspReq = (state == ST_HANDSHAKE) || (state == ST_STOPPED) || (state == ST_RESYNC);
  assign smiHold = (state == ST_RESYNC);

  // R3: the clocks stop only after an enabled, acknowledged handshake
  a_r3_stop_needs_ack_en: assert property (@(posedge clkSlow) disable iff (!rstN)
    $rose(clkStop) |-> ($past(ackS) && $past(enS) && $past(suspReq)));

  // R8: SMI hold and clock stop are mutually exclusive
  a_r8_no_overlap: assert property (@(posedge clkSlow) disable iff (!rstN)
    !(clkStop && smiHold));

  // R8: SMI is only driven while the request is held
  a_r8_smi_under_req: assert property (@(posedge clkSlow) disable iff (!rstN)
    smiHold |-> suspReq);

  // R5: SMI and the request are released in the same cycle
  a_r5_joint_release: assert property (@(posedge clkSlow) disable iff (!rstN)
    $fell(smiHold) |-> !suspReq);

  // R7: a wake during the handshake never leads to stopped clocks or SMI
  a_r7_abort: assert property (@(posedge clkSlow) disable iff (!rstN)
    (suspReq && !clkStop && !smiHold && wakeS) |=> (!clkStop && !smiHold));

  // R4: a wake while stopped restarts the clocks at the next edge
  a_r4_wake_restart: assert property (@(posedge clkSlow) disable iff (!rstN)
    (clkStop && wakeS) |=> (!clkStop && smiHold));

endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
  import clk_stop_seq_pkg::*;
#(
  parameter int DELAY_W     = 4,
  parameter int CYC_PER_MS  = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clkSlow,
  input  logic               rstN,
  input  logic               suspendGo,
  input  logic               procAck,
  input  logic               stopEn,
  input  logic               smiWake,
  input  logic               irqWake,
  input  logic [DELAY_W-1:0] resyncMs,
  output logic               clkStop,
  output logic               suspReq,
  output logic               smiHold
);

  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] rawIn, syncIn;
  cntStrobe_t        strobe;
  logic              cntZero;

  assign rawIn = {suspendGo, procAck, stopEn, smiWake | irqWake};

  clk_stop_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clkSlow (clkSlow),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  clk_stop_ctrl u_ctrl (
    .clkSlow (clkSlow),
    .rstN    (rstN),
    .goS     (syncIn[3]),
    .ackS    (syncIn[2]),
    .enS     (syncIn[1]),
    .wakeS   (syncIn[0]),
    .cntZero (cntZero),
    .strobe  (strobe),
    .clkStop (clkStop),
    .suspReq (suspReq),
    .smiHold (smiHold)
  );

  clk_stop_datapath #(.DELAY_W(DELAY_W), .CYC_PER_MS(CYC_PER_MS)) u_dp (
    .clkSlow (clkSlow),
    .rstN    (rstN),
    .strobe  (strobe),
    .delayMs (resyncMs),
    .cntZero (cntZero)
  );

endmodule

// File: tb/clk_stop_seq_tb.sv
module clk_stop_seq_tb;

  localparam int CLK_PERIOD = 30;
  localparam int CYC_MS     = 33;
  localparam int NVEC       = 6;
  // each entry: {resync ms [4:1], use irq instead of smi [0]}
  localparam logic [4:0] VEC [NVEC] = '{
    {4'd0, 1'b0}, {4'd1, 1'b1}, {4'd5, 1'b0},
    {4'd15, 1'b1}, {4'd2, 1'b0}, {4'd9, 1'b1}
  };

  logic clkSlow = 1'b0;
  logic rstN = 1'b0;
  logic suspendGo = 1'b0, procAck = 1'b0, stopEn = 1'b0;
  logic smiWake = 1'b0, irqWake = 1'b0;
  logic [3:0] resyncMs = '0;
  logic clkStop, suspReq, smiHold;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clkSlow = ~clkSlow;

  clk_stop_seq u_dut (
    .clkSlow(clkSlow), .rstN(rstN), .suspendGo(suspendGo), .procAck(procAck),
    .stopEn(stopEn), .smiWake(smiWake), .irqWake(irqWake), .resyncMs(resyncMs),
    .clkStop(clkStop), .suspReq(suspReq), .smiHold(smiHold)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clkSlow);
    @(negedge clkSlow);
  endtask

  task automatic expect3(input string req, input logic eStop, input logic eReq, input logic eSmi);
    checks++;
    if ({clkStop, suspReq, smiHold} !== {eStop, eReq, eSmi}) begin
      errors++;
      $display("FAIL %s: got stop/req/smi=%b%b%b expected %b%b%b at %0t",
               req, clkStop, suspReq, smiHold, eStop, eReq, eSmi, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    expect3("R1 reset", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    edges(2);
    expect3("R1 after reset", 1'b0, 1'b0, 1'b0);

    // table-driven full suspend cycles: R2, R3, R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      resyncMs  = VEC[v][4:1];
      stopEn    = 1'b1;
      suspendGo = 1'b1;
      edges(3);
      expect3("R2 request raised", 1'b0, 1'b1, 1'b0);
      procAck = 1'b1;
      edges(3);
      expect3("R3 clocks stopped", 1'b1, 1'b1, 1'b0);
      suspendGo = 1'b0;
      procAck   = 1'b0;
      edges(4);
      expect3("R3 stop held", 1'b1, 1'b1, 1'b0);
      if (VEC[v][0]) irqWake = 1'b1; else smiWake = 1'b1;
      edges(3);
      expect3("R4 wake restart", 1'b0, 1'b1, 1'b1);
      irqWake = 1'b0;
      smiWake = 1'b0;
      if (VEC[v][4:1] != 0) begin
        edges(int'(VEC[v][4:1]) * CYC_MS);
        expect3("R5 window end held", 1'b0, 1'b1, 1'b1);
        edges(1);
        expect3("R5 released", 1'b0, 1'b0, 1'b0);
      end else begin
        edges(1);
        expect3("R6 zero delay released", 1'b0, 1'b0, 1'b0);
      end
      edges(3);
      expect3("R8 back idle", 1'b0, 1'b0, 1'b0);
    end

    // R5: one cycle short of the window end, mid-range setting
    resyncMs = 4'd3; stopEn = 1'b1; suspendGo = 1'b1;
    edges(3); procAck = 1'b1;
    edges(3); suspendGo = 1'b0; procAck = 1'b0;
    smiWake = 1'b1;
    edges(3); smiWake = 1'b0;
    edges(3 * CYC_MS - 1);
    expect3("R5 mid window", 1'b0, 1'b1, 1'b1);
    edges(3);
    expect3("R5 after window", 1'b0, 1'b0, 1'b0);

    // R3: stop disabled, acknowledged handshake keeps clocks running
    stopEn = 1'b0; suspendGo = 1'b1; procAck = 1'b1;
    edges(6);
    expect3("R3 disabled no stop", 1'b0, 1'b1, 1'b0);
    suspendGo = 1'b0; procAck = 1'b0; irqWake = 1'b1;
    edges(3);
    expect3("R7 exit from held request", 1'b0, 1'b0, 1'b0);
    irqWake = 1'b0;
    edges(3);

    // R7: wake during handshake aborts entry
    stopEn = 1'b1; suspendGo = 1'b1;
    edges(3);
    expect3("R7 handshake", 1'b0, 1'b1, 1'b0);
    suspendGo = 1'b0; smiWake = 1'b1;
    edges(3);
    expect3("R7 aborted", 1'b0, 1'b0, 1'b0);
    procAck = 1'b1;
    edges(4);
    expect3("R7 late ack ignored", 1'b0, 1'b0, 1'b0);
    smiWake = 1'b0; procAck = 1'b0;
    edges(3);

    // R9: wakes in idle have no effect
    smiWake = 1'b1; irqWake = 1'b1;
    edges(5);
    expect3("R9 idle wake", 1'b0, 1'b0, 1'b0);
    smiWake = 1'b0; irqWake = 1'b0;
    edges(3);
    expect3("R9 idle after wake", 1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule